// File: doc/BRIEF.md
# Interval Timer Bus Front End

This block is the processor-facing side of a three-channel interval timer. It sits on an 8-bit register bus with four addresses: one data port per channel and one write-only control port. Control words set each channel's operating mode code, its binary or BCD flag and its byte access format. They can also freeze channel counts into holding registers. Data writes are assembled into 16-bit counts and handed to the channel with a single-cycle load strobe. Data reads return one byte of either the live count or a frozen snapshot.

The counting engines are outside this block. Each channel engine takes the load strobe, the count, the mode code and the BCD flag from here, and it returns its present count on the live count input. Each channel keeps its own format, its own write byte toggle, its own read byte toggle and its own snapshot. Several channels can therefore be programmed in interleaved order without disturbing one another.

Top module: `tmr_bus_if`

## Requirements
- R1: After reset every channel has format low-then-high, mode code 0 and BCD flag 0. All load strobes are low, all count outputs are 0 and rd_data is 0.
- R2: A write to address 3 with bits 7:6 = 00, 01 or 10 selects channel 0, 1 or 2. When bits 5:4 are not 00, bits 5:4 set that channel's format (01 high byte only, 10 low byte only, 11 low then high), bits 3:1 appear on its mode output and bit 0 appears on its BCD output. Only the selected channel changes.
- R3: In low-only format, a data write of byte d to address n sets channel n's count to {8'h00, d}. The load strobe rises on the clock edge that captures the write and lasts one cycle.
- R4: In high-only format, a data write of byte d sets the count to {d, 8'h00} and raises the load strobe in the same way.
- R5: In low-then-high format, the first data write only stores the low byte, with no strobe. The second write sets the count to {second, first} and raises the strobe.
- R6: A control word for a channel with a non-zero format returns both of its byte toggles to the low byte and discards any pending snapshot.
- R7: A read of address n returns its byte on rd_data one cycle after rd_en. Low-only format returns the low byte, high-only format returns the high byte, and low-then-high format alternates low, high, low and so on. rd_data holds its value between reads.
- R8: A control word with bits 5:4 = 00 copies the selected channel's live count into its snapshot and leaves mode and format unchanged. Reads return the snapshot until it is released: after the high byte in low-then-high format, or after the single byte otherwise. A further snapshot request while one is pending is ignored.
- R9: A control word with bits 7:6 = 11 takes a snapshot, in the same cycle, of every channel whose select bit is set: bit 1 for channel 0, bit 2 for channel 1 and bit 3 for channel 2.
- R10: A data write raises the load strobe only of the addressed channel. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Port address (0-2 channel data, 3 control) |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| ch_live | input | 48 | Live 16-bit count from each channel engine, channel 0 in the low bits |
| ch_load | output | 3 | One-cycle load strobe per channel |
| ch_count | output | 48 | Assembled 16-bit count per channel |
| ch_mode | output | 9 | 3-bit mode code per channel |
| ch_bcd | output | 3 | BCD flag per channel |

## Verification
On every cycle the assertions check four things. A load strobe appears only after a data write to that channel's address. A count output changes only together with its strobe. A mode output changes only after a non-latch control word that selects that channel. rd_data moves only after a read, and a read of address 3 gives zero. The bench scenarios are needed to show byte assembly order, alternating read order, how toggles reset after a control word, the snapshot being held across two reads and released, a second snapshot being ignored, and a read-back command latching several channels at once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    FMT_SNAP = 2'b00,
    FMT_HI   = 2'b01,
    FMT_LO   = 2'b10,
    FMT_LOHI = 2'b11
  } acc_fmt_e;

  localparam logic [1:0] SEL_READBACK = 2'b11;
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode #(
  parameter int NCH = 3,
  parameter int AW  = 2,
  parameter int BW  = 8
) (
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [BW-1:0]       wr_data,
  output logic [NCH-1:0]      ctl_hit,
  output logic [NCH-1:0]      snap_req,
  output logic [NCH-1:0]      wr_hit,
  output logic [NCH-1:0]      rd_hit,
  output tmr_pkg::acc_fmt_e   fmt,
  output logic [2:0]          mode,
  output logic                bcd
);
  import tmr_pkg::*;

  localparam logic [AW-1:0] CTL_ADDR = AW'(NCH);

  logic       ctl_wr;
  logic [1:0] sel;

  assign ctl_wr = wr_en && (addr == CTL_ADDR);
  assign sel    = wr_data[7:6];
  assign fmt    = acc_fmt_e'(wr_data[5:4]);
  assign mode   = wr_data[3:1];
  assign bcd    = wr_data[0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic named;
    assign named       = ctl_wr && (sel == 2'(i));
    assign ctl_hit[i]  = named && (fmt != FMT_SNAP);
    assign snap_req[i] = (named && (fmt == FMT_SNAP)) ||
                         (ctl_wr && (sel == SEL_READBACK) && wr_data[i+1]);
    assign wr_hit[i]   = wr_en && (addr == AW'(i));
    assign rd_hit[i]   = rd_en && (addr == AW'(i));
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_hit,
  input  logic              snap_req,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  tmr_pkg::acc_fmt_e ctl_fmt,
  input  logic [2:0]        ctl_mode,
  input  logic              ctl_bcd,
  input  logic [BW-1:0]     wr_data,
  input  logic [CW-1:0]     live,
  output logic              load,
  output logic [CW-1:0]     count,
  output logic [2:0]        mode,
  output logic              bcd,
  output logic [BW-1:0]     rd_byte
);
  import tmr_pkg::*;

  acc_fmt_e      fmt_q;
  logic          wr_tog, rd_tog, held_v;
  logic [BW-1:0] low_q;
  logic [CW-1:0] held_q, src;
  logic          pick_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q  <= FMT_LOHI;
      mode   <= '0;
      bcd    <= 1'b0;
      wr_tog <= 1'b0;
      rd_tog <= 1'b0;
      low_q  <= '0;
      held_q <= '0;
      held_v <= 1'b0;
      load   <= 1'b0;
      count  <= '0;
    end else begin
      load <= 1'b0;
      if (wr_hit) begin
        unique case (fmt_q)
          FMT_LO: begin
            count <= {{BW{1'b0}}, wr_data};
            load  <= 1'b1;
          end
          FMT_HI: begin
            count <= {wr_data, {BW{1'b0}}};
            load  <= 1'b1;
          end
          default: begin
            if (!wr_tog) begin
              low_q  <= wr_data;
              wr_tog <= 1'b1;
            end else begin
              count  <= {wr_data, low_q};
              load   <= 1'b1;
              wr_tog <= 1'b0;
            end
          end
        endcase
      end
      if (rd_hit) begin
        if (fmt_q == FMT_LOHI) rd_tog <= ~rd_tog;
        if (held_v && (fmt_q != FMT_LOHI || rd_tog)) held_v <= 1'b0;
      end
      if (ctl_hit) begin
        fmt_q  <= ctl_fmt;
        mode   <= ctl_mode;
        bcd    <= ctl_bcd;
        wr_tog <= 1'b0;
        rd_tog <= 1'b0;
        held_v <= 1'b0;
      end else if (snap_req && !held_v) begin
        held_q <= live;
        held_v <= 1'b1;
      end
    end
  end

  assign src     = held_v ? held_q : live;
  assign pick_hi = (fmt_q == FMT_HI) || (fmt_q == FMT_LOHI && rd_tog);
  assign rd_byte = pick_hi ? src[CW-1:BW] : src[BW-1:0];
endmodule

// File: rtl/tmr_bus_if.sv
module tmr_bus_if #(
  parameter int NCH = 3,
  parameter int AW  = 2,
  parameter int BW  = 8,
  localparam int CW = 2 * BW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      addr,
  input  logic [BW-1:0]      wr_data,
  output logic [BW-1:0]      rd_data,
  input  logic [NCH*CW-1:0]  ch_live,
  output logic [NCH-1:0]     ch_load,
  output logic [NCH*CW-1:0]  ch_count,
  output logic [NCH*3-1:0]   ch_mode,
  output logic [NCH-1:0]     ch_bcd
);
  import tmr_pkg::*;

  logic [NCH-1:0] ctl_hit, snap_req, wr_hit, rd_hit;
  acc_fmt_e       dec_fmt;
  logic [2:0]     dec_mode;
  logic           dec_bcd;
  logic [BW-1:0]  rd_byte [NCH];
  logic [BW-1:0]  rd_sel;

  tmr_ctl_decode #(.NCH(NCH), .AW(AW), .BW(BW)) u_dec (
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .ctl_hit  (ctl_hit),
    .snap_req (snap_req),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit),
    .fmt      (dec_fmt),
    .mode     (dec_mode),
    .bcd      (dec_bcd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    tmr_chan_port #(.BW(BW)) u_port (
      .clk      (clk),
      .rst      (rst),
      .ctl_hit  (ctl_hit[i]),
      .snap_req (snap_req[i]),
      .wr_hit   (wr_hit[i]),
      .rd_hit   (rd_hit[i]),
      .ctl_fmt  (dec_fmt),
      .ctl_mode (dec_mode),
      .ctl_bcd  (dec_bcd),
      .wr_data  (wr_data),
      .live     (ch_live[i*CW +: CW]),
      .load     (ch_load[i]),
      .count    (ch_count[i*CW +: CW]),
      .mode     (ch_mode[i*3 +: 3]),
      .bcd      (ch_bcd[i]),
      .rd_byte  (rd_byte[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NCH; i++)
      if (addr == AW'(i)) rd_sel = rd_byte[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_sel;
  end
endmodule

// File: rtl/tmr_bus_if_chk.sv
module tmr_bus_if_chk #(
  parameter int NCH = 3,
  parameter int AW  = 2,
  parameter int BW  = 8,
  localparam int CW = 2 * BW
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic [BW-1:0]     wr_data,
  input logic [BW-1:0]     rd_data,
  input logic [NCH-1:0]    ch_load,
  input logic [NCH*CW-1:0] ch_count,
  input logic [NCH*3-1:0]  ch_mode
);
  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R10: strobe only for the addressed channel
    a_r10_load_addressed: assert property (@(posedge clk) disable iff (rst)
      ch_load[i] |-> $past(wr_en && addr == AW'(i)));
    // R3: count output moves only with its strobe
    a_r3_count_with_load: assert property (@(posedge clk) disable iff (rst)
      !$stable(ch_count[i*CW +: CW]) |-> ch_load[i]);
    // R2: mode changes only after a control word naming this channel
    a_r2_mode_source: assert property (@(posedge clk) disable iff (rst)
      !$stable(ch_mode[i*3 +: 3]) |->
        $past(wr_en && addr == AW'(NCH) && wr_data[7:6] == 2'(i) && wr_data[5:4] != 2'b00));
  end

  // R7: read byte holds between reads
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_data));
  // R10: control address reads as zero
  a_r10_ctl_read_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr == AW'(NCH)) |-> rd_data == '0);
endmodule

bind tmr_bus_if tmr_bus_if_chk #(.NCH(NCH), .AW(AW), .BW(BW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .ch_load  (ch_load),
  .ch_count (ch_count),
  .ch_mode  (ch_mode)
);

// File: tb/tmr_bus_if_tb.sv
module tmr_bus_if_tb;
  localparam int NCH = 3;
  localparam int CW  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]        addr = '0;
  logic [7:0]        wr_data = '0;
  logic [7:0]        rd_data;
  logic [NCH*CW-1:0] ch_live = '0;
  logic [NCH-1:0]    ch_load, ch_bcd;
  logic [NCH*CW-1:0] ch_count;
  logic [NCH*3-1:0]  ch_mode;

  int n_chk = 0, n_bad = 0;
  logic [7:0] b;

  always #2.5 clk = ~clk;

  tmr_bus_if u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ch_live(ch_live),
    .ch_load(ch_load), .ch_count(ch_count), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [15:0] cnt(input int i);
    return ch_count[i*CW +: CW];
  endfunction

  task automatic t_reset();
    chk("R1 modes", 32'(ch_mode), 0);
    chk("R1 bcd", 32'(ch_bcd), 0);
    chk("R1 load", 32'(ch_load), 0);
    chk("R1 count", 32'(ch_count[31:0]), 0);
    chk("R1 rd_data", 32'(rd_data), 0);
  endtask

  task automatic t_control();
    bus_wr(2'd3, 8'b01_10_101_1);
    chk("R2 ch1 mode", 32'(ch_mode[5:3]), 5);
    chk("R2 ch1 bcd", 32'(ch_bcd[1]), 1);
    chk("R2 other modes", 32'({ch_mode[8:6], ch_mode[2:0]}), 0);
    bus_wr(2'd3, 8'b10_01_010_0);
    chk("R2 ch2 mode", 32'(ch_mode[8:6]), 2);
  endtask

  task automatic t_lo_write();
    bus_wr(2'd1, 8'hA5);
    chk("R3 load ch1", 32'(ch_load), 3'b010);
    chk("R3 count ch1", 32'(cnt(1)), 16'h00A5);
    @(negedge clk);
    chk("R3 strobe one cycle", 32'(ch_load), 0);
  endtask

  task automatic t_hi_write();
    bus_wr(2'd2, 8'h5C);
    chk("R4 load ch2", 32'(ch_load), 3'b100);
    chk("R4 count ch2", 32'(cnt(2)), 16'h5C00);
  endtask

  task automatic t_lohi_write();
    bus_wr(2'd0, 8'h34);
    chk("R5 no load after low", 32'(ch_load), 0);
    bus_wr(2'd0, 8'h12);
    chk("R5 load after high", 32'(ch_load), 3'b001);
    chk("R5 count ch0", 32'(cnt(0)), 16'h1234);
  endtask

  task automatic t_reads();
    ch_live = {16'h2468, 16'h1357, 16'hBEEF};
    bus_rd(2'd0, b); chk("R7 lohi first low", 32'(b), 8'hEF);
    bus_rd(2'd0, b); chk("R7 lohi then high", 32'(b), 8'hBE);
    bus_rd(2'd1, b); chk("R7 low only", 32'(b), 8'h57);
    bus_rd(2'd2, b); chk("R7 high only", 32'(b), 8'h24);
    bus_rd(2'd3, b); chk("R10 ctl addr reads 0", 32'(b), 0);
  endtask

  task automatic t_toggle_reset();
    bus_wr(2'd0, 8'h77);
    bus_wr(2'd3, 8'b00_11_011_0);
    bus_wr(2'd0, 8'h11);
    chk("R6 write toggle back to low", 32'(ch_load), 0);
    bus_wr(2'd0, 8'h22);
    chk("R6 count after reset toggle", 32'(cnt(0)), 16'h2211);
    bus_rd(2'd0, b);
    bus_wr(2'd3, 8'b00_11_011_0);
    bus_rd(2'd0, b); chk("R6 read toggle back to low", 32'(b), 8'hEF);
    bus_rd(2'd0, b); chk("R6 then high", 32'(b), 8'hBE);
  endtask

  task automatic t_latch();
    ch_live[15:0] = 16'h4321;
    bus_wr(2'd3, 8'b00_00_000_0);
    chk("R8 mode kept", 32'(ch_mode[2:0]), 3);
    ch_live[15:0] = 16'h9988;
    bus_rd(2'd0, b); chk("R8 held low", 32'(b), 8'h21);
    bus_wr(2'd3, 8'b00_00_000_0);
    bus_rd(2'd0, b); chk("R8 held high, second snapshot ignored", 32'(b), 8'h43);
    bus_rd(2'd0, b); chk("R8 released to live", 32'(b), 8'h88);
    bus_rd(2'd0, b);
    bus_wr(2'd3, 8'b00_00_000_0);
    ch_live[15:0] = 16'h5566;
    bus_wr(2'd3, 8'b00_11_011_0);
    bus_rd(2'd0, b); chk("R6 control word drops snapshot", 32'(b), 8'h66);
  endtask

  task automatic t_readback();
    bus_wr(2'd3, 8'b00_11_000_0);
    ch_live = {16'h3333, 16'h2222, 16'h1111};
    bus_wr(2'd3, 8'b11_00_101_0);
    ch_live = {16'hCCCC, 16'hAAAA, 16'hBBBB};
    bus_rd(2'd0, b); chk("R9 ch0 latched low", 32'(b), 8'h11);
    bus_rd(2'd0, b); chk("R9 ch0 latched high", 32'(b), 8'h11);
    bus_rd(2'd1, b); chk("R9 ch1 not selected", 32'(b), 8'hAA);
    bus_rd(2'd2, b); chk("R9 ch2 latched", 32'(b), 8'h33);
    bus_rd(2'd2, b); chk("R9 ch2 released", 32'(b), 8'hCC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_control();
    t_lo_write();
    t_hi_write();
    t_lohi_write();
    t_reads();
    t_toggle_reset();
    t_latch();
    t_readback();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule